// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single timer channel that counts down from a programmed start value. It advances on a reference tick that is supplied as a one-cycle enable, `ref_tick`, in the system clock domain. A prescaler divides the tick rate by (prescale + 1). When the count runs out, the channel emits a one-cycle terminal pulse. It then either reloads and keeps running (periodic mode) or disarms itself (one-shot mode).

Software reaches the channel through three word-wide registers, and each has its own write strobe:

- **Control/status word.** Holds the enable, interrupt enable, periodic mode, self-clearing counter reset, read-only active flag and an 8-bit prescale field.
- **Start-value register.** Holds the value loaded into the counter.
- **Live-count register.** Read-only; returns the remaining count.

The interrupt-enable bit is exported unchanged so that a separate status block can gate the terminal pulse.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the control word reads 0x00000005 (prescale 5, all flags clear), the start value and live count read 0, `tc_pulse` is 0 and `irq_en` is 0.
- R2: A control write changes only these fields, whose positions are fixed:
  - bit 30: enable
  - bit 29: interrupt enable
  - bit 27: periodic mode
  - bits 7:0: prescale

  Written values in bits 24:8, bit 25 (active), bit 28 and bit 31 are discarded. These bits read 0, except bit 25, which reflects the active flag.
- R3: A control write with bit 26 (counter reset) set reloads the live count from the start value and drops bit 30 of that same write. Bit 26 always reads 0.
- R4: While enabled, the live count decrements once per (prescale + 1) `ref_tick` pulses.
- R5: An enable change from 0 to 1 sets the active flag (bit 25) and resumes from the current count. A change from 1 to 0 clears the active flag and freezes the count.
- R6: In periodic mode (bit 27 = 1), the count step that would reach zero pulses `tc_pulse` high for one cycle and reloads the start value. Counting continues.
- R7: In one-shot mode (bit 27 = 0), the count step that reaches zero pulses `tc_pulse`, leaves the count at 0, and clears both enable and active.
- R8: A start-value write loads the live count with the new value in the same cycle and restarts the prescaler phase.
- R9: Writes to the live-count register have no effect on any register.
- R10: A start value of 0 produces a terminal pulse on the first count step after enable. In periodic mode a pulse follows on every count step.
- R11: Changing the prescale value keeps the live count and restarts the prescaler phase, so the next step comes a full new period later.
- R12: `irq_en` always equals the interrupt-enable bit (bit 29) of the control word.
- R13: While disabled, `ref_tick` pulses change neither the count nor the prescaler phase. A cycle carrying a control or start-value write does not count a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| ctl_wr | input | 1 | Control word write strobe |
| start_wr | input | 1 | Start-value write strobe |
| live_wr | input | 1 | Live-count write strobe (ignored) |
| wdata | input | 32 | Write data shared by all strobes |
| ctl_rdata | output | 32 | Control/status word read value |
| start_rdata | output | 32 | Start-value read value |
| live_rdata | output | 32 | Remaining count |
| irq_en | output | 1 | Interrupt-enable bit for the external status block |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The hardest case to reach from the ports is a prescale change in the middle of a prescaler period. It shows whether the phase restarts, and it only becomes visible a full period later.

The stimulus places the channel one tick into a two-tick period, then rewrites the prescale to four ticks. It checks that three further ticks leave the count unchanged and that the fourth tick decrements it.

A second awkward case is a control write that sets both counter reset and enable. This is driven while the channel is running with a partly consumed count, so the reload and the dropped enable are both observable.

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             ctl_wr,
  input  logic             start_wr,
  input  logic             live_wr,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctl_rdata,
  output logic [CNT_W-1:0] start_rdata,
  output logic [CNT_W-1:0] live_rdata,
  output logic             irq_en,
  output logic             tc_pulse
);
  localparam int B_EN  = 30;
  localparam int B_IE  = 29;
  localparam int B_PER = 27;
  localparam int B_RST = 26;
  localparam int B_ACT = 25;
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(5);

  logic             en_q, ie_q, per_q, act_q, tc_q;
  logic [PRE_W-1:0] pre_q, phase_q;
  logic [CNT_W-1:0] start_q, cnt_q;

  wire             wr_any  = ctl_wr | start_wr;
  wire             tick_go = en_q & ref_tick & ~wr_any;
  wire             step    = tick_go & (phase_q == pre_q);
  wire             term    = step & (cnt_q <= CNT_W'(1));
  wire             w_rst   = wdata[B_RST];
  wire             w_en    = wdata[B_EN] & ~w_rst;
  wire [PRE_W-1:0] w_pre   = wdata[PRE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      per_q   <= 1'b0;
      act_q   <= 1'b0;
      pre_q   <= PRE_RST;
      phase_q <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= term;
      if (ctl_wr) begin
        en_q  <= w_en;
        act_q <= w_en;
        ie_q  <= wdata[B_IE];
        per_q <= wdata[B_PER];
        pre_q <= w_pre;
        if (w_pre != pre_q || w_rst) phase_q <= '0;
        if (w_rst) cnt_q <= start_q;
      end else if (start_wr) begin
        start_q <= wdata[CNT_W-1:0];
        cnt_q   <= wdata[CNT_W-1:0];
        phase_q <= '0;
      end else if (tick_go) begin
        phase_q <= step ? '0 : phase_q + PRE_W'(1);
        if (term) begin
          if (per_q) begin
            cnt_q <= start_q;
          end else begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            act_q <= 1'b0;
          end
        end else if (step) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctl_rdata              = '0;
    ctl_rdata[B_EN]        = en_q;
    ctl_rdata[B_IE]        = ie_q;
    ctl_rdata[B_PER]       = per_q;
    ctl_rdata[B_ACT]       = act_q;
    ctl_rdata[PRE_W-1:0]   = pre_q;
  end

  assign start_rdata = start_q;
  assign live_rdata  = cnt_q;
  assign irq_en      = ie_q;
  assign tc_pulse    = tc_q;

  // R5: active flag tracks the enable state
  a_r5_act_tracks_en: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == en_q);

  // R7: a one-shot terminal event leaves the channel disarmed
  a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !per_q) |-> (!en_q && !act_q && live_rdata == '0));

  // R6: a periodic terminal event has reloaded the start value
  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && per_q) |-> (live_rdata == start_rdata));

  // R13: no count movement while disabled without writes
  a_r13_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctl_wr && !start_wr) |=> $stable(live_rdata));

  // R9: a live-count write alone changes nothing while idle
  a_r9_live_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && !wr_any && !en_q) |=> ($stable(live_rdata) && $stable(ctl_rdata)));

  // R3: counter reset always drops the enable of that write
  a_r3_rst_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[B_RST]) |=> !ctl_rdata[B_EN]);
endmodule

// File: tb/tick_down_timer_tb.sv
module tick_down_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        ctl_wr = 1'b0, start_wr = 1'b0, live_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ctl_rdata, start_rdata, live_rdata;
  logic        irq_en, tc_pulse;

  int errors = 0;
  int checks = 0;
  int pulses = 0;

  always #10 clk = ~clk;

  tick_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .ctl_wr(ctl_wr), .start_wr(start_wr), .live_wr(live_wr), .wdata(wdata),
    .ctl_rdata(ctl_rdata), .start_rdata(start_rdata), .live_rdata(live_rdata),
    .irq_en(irq_en), .tc_pulse(tc_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [31:0] d);
    wdata = d;
    ctl_wr = (which == 0);
    start_wr = (which == 1);
    live_wr = (which == 2);
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 1'b0; start_wr = 1'b0; live_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    ref_tick = 1'b1;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (tc_pulse) pulses++;
    end
    ref_tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ctl", ctl_rdata, 32'h0000_0005);
    check("R1 start", start_rdata, 32'h0);
    check("R1 live", live_rdata, 32'h0);
    check("R1 tc", {31'b0, tc_pulse}, 32'h0);
    check("R12 irq_en reset", {31'b0, irq_en}, 32'h0);
  endtask

  task automatic t_fields;
    wr(0, 32'h23FF_FF03);
    check("R2 masked readback", ctl_rdata, 32'h2000_0003);
    check("R12 irq_en set", {31'b0, irq_en}, 32'h1);
    wr(0, 32'h0000_0003);
    check("R12 irq_en clear", {31'b0, irq_en}, 32'h0);
  endtask

  task automatic t_rst_with_en;
    wr(1, 32'd10);
    wr(0, 32'h4000_0000);
    check("R5 active on enable", ctl_rdata, 32'h4200_0000);
    tick(3);
    check("R4 prescale0 steps", live_rdata, 32'd7);
    wr(0, 32'h4400_0000);
    check("R3 enable dropped", ctl_rdata, 32'h0);
    check("R3 reload", live_rdata, 32'd10);
    tick(2);
    check("R13 hold when off", live_rdata, 32'd10);
  endtask

  task automatic t_prescale;
    wr(0, 32'h4000_0002);
    check("R5 enable readback", ctl_rdata, 32'h4200_0002);
    tick(2);
    check("R4 before period", live_rdata, 32'd10);
    tick(1);
    check("R4 one step", live_rdata, 32'd9);
    tick(6);
    check("R4 two steps", live_rdata, 32'd7);
  endtask

  task automatic t_freeze;
    wr(0, 32'h0000_0002);
    check("R5 active cleared", ctl_rdata, 32'h0000_0002);
    tick(5);
    check("R5 frozen", live_rdata, 32'd7);
    wr(0, 32'h4000_0002);
    tick(3);
    check("R5 resumed", live_rdata, 32'd6);
  endtask

  task automatic t_live_wr;
    wr(2, 32'h0000_1234);
    check("R9 live unchanged", live_rdata, 32'd6);
    check("R9 start unchanged", start_rdata, 32'd10);
    check("R9 ctl unchanged", ctl_rdata, 32'h4200_0002);
  endtask

  task automatic t_start_reload;
    wr(1, 32'd4);
    check("R8 immediate load", live_rdata, 32'd4);
    check("R8 start value", start_rdata, 32'd4);
  endtask

  task automatic t_periodic;
    wr(0, 32'h4800_0000);
    check("R6 ctl", ctl_rdata, 32'h4A00_0000);
    pulses = 0;
    tick(3);
    check("R6 no early pulse", pulses, 0);
    tick(1);
    check("R6 first pulse", pulses, 1);
    check("R6 reloaded", live_rdata, 32'd4);
    tick(8);
    check("R6 repeats", pulses, 3);
    check("R6 still running", ctl_rdata, 32'h4A00_0000);
  endtask

  task automatic t_pre_change;
    wr(0, 32'h4800_0001);
    tick(1);
    check("R11 mid period", live_rdata, 32'd4);
    wr(0, 32'h4800_0003);
    check("R11 count kept", live_rdata, 32'd4);
    tick(3);
    check("R11 phase restarted", live_rdata, 32'd4);
    tick(1);
    check("R11 step after new period", live_rdata, 32'd3);
  endtask

  task automatic t_oneshot;
    wr(0, 32'h4000_0000);
    pulses = 0;
    tick(3);
    check("R7 pulse", pulses, 1);
    check("R7 disarmed", ctl_rdata, 32'h0);
    check("R7 count zero", live_rdata, 32'd0);
    tick(3);
    check("R7 no further pulse", pulses, 1);
  endtask

  task automatic t_zero_start;
    wr(1, 32'd0);
    wr(0, 32'h4800_0000);
    pulses = 0;
    tick(1);
    check("R10 first tick", pulses, 1);
    tick(4);
    check("R10 every tick", pulses, 5);
    check("R10 count zero", live_rdata, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_rst_with_en();
    t_prescale();
    t_freeze();
    t_live_wr();
    t_start_reload();
    t_periodic();
    t_pre_change();
    t_oneshot();
    t_zero_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule